// File: doc/BRIEF.md
# APB Control and Status Register Block

This block is the software-visible face of a small peripheral. It sits on an APB slave port and holds three 32-bit words. The first is a constant identification word that carries a major revision, a minor revision and a capability mask. The second is a read-write control word whose fields drive the peripheral core. The third is a status word that shows the core's busy line and holds a done flag. The core sets that flag and software clears it.

Every transfer completes with zero wait states. Writes take effect on the clock edge that ends the access phase, and read data comes combinationally from a multiplexer selected by the decoded address. Software enables an interrupt through the control enable bit, and the pending condition is the done flag.

Top module: `apb_csr_block`

## Requirements
- R1: A read of offset 0x00 returns 0x0102_0003: major revision 0x01 in bits [31:24], minor revision 0x02 in bits [23:16] and capability mask 0x0003 in bits [15:0].
- R2: After reset, the control word (0x04) and the status word (0x08, with the busy input low) both read 0.
- R3: A write to 0x04 stores the enable bit from bit 0, the 3-bit mode from bits [3:1] and the 16-bit threshold from bits [31:16], and drives them onto ctl_en, ctl_mode and ctl_thresh. Control bits [15:4] always read 0, so a mode value never appears at bits [5:3].
- R4: A register changes only on a clock edge where psel, penable and pwrite are all high. A setup phase alone (psel high, penable low) writes nothing.
- R5: Status bit 0 reads the core_busy input, and bus writes have no effect on it.
- R6: A core_done_set pulse sets status bit 1 on the next edge. Writing 1 to bit 1 of 0x08 clears the flag, and writing 0 to that bit leaves it unchanged.
- R7: When core_done_set and a write-1 clear of the done flag occur on the same edge, the flag ends up set.
- R8: irq is high exactly when the done flag and the control enable bit are both 1.
- R9: Reads of offsets other than 0x00, 0x04 and 0x08 return 0, and writes to them change nothing. pready is always 1 and pslverr is always 0.
- R10: Writes to 0x00 leave the identification word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational |
| pready | output | 1 | Transfer complete, always 1 |
| pslverr | output | 1 | Error response, always 0 |
| core_busy | input | 1 | Busy level from the core |
| core_done_set | input | 1 | One-cycle pulse that sets the done flag |
| ctl_en | output | 1 | Control enable bit |
| ctl_mode | output | 3 | Control mode field |
| ctl_thresh | output | 16 | Control threshold field |
| irq | output | 1 | Done flag gated by the enable bit |

## Verification
Read data depends only on the current bus inputs and the stored state, so the bench samples prdata in the access-phase cycle itself, one time unit after it raises penable. Control writes and done-flag updates land on the single rising edge that closes the access phase or the set pulse, and irq follows combinationally. The bench therefore samples ctl_* outputs, irq and read-backs at the falling edge after that edge, never on the edge itself. The bench keeps the core's set pulse high for exactly one rising edge, so it can place the pulse on the same edge as a clear when it needs the two to coincide.

// File: rtl/apb_csr_pkg.sv
package apb_csr_pkg;
   localparam int unsigned OFS_IDENT  = 8'h00;
   localparam int unsigned OFS_CONTROL = 8'h04;
   localparam int unsigned OFS_STATUS = 8'h08;

   typedef enum logic [1:0] {
      RSEL_IDENT   = 2'd0,
      RSEL_CONTROL = 2'd1,
      RSEL_STATUS  = 2'd2,
      RSEL_NONE    = 2'd3
   } rsel_e;
endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
   import apb_csr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   output logic              wr_control,
   output logic              wr_status,
   output rsel_e             rsel
);
   logic access_wr;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("csr_addr_decode: ADDR_W must cover offset 0x08");
   end

   assign access_wr = psel && penable && pwrite;

   always_comb begin
      rsel = RSEL_NONE;
      if (paddr == ADDR_W'(OFS_IDENT))        rsel = RSEL_IDENT;
      else if (paddr == ADDR_W'(OFS_CONTROL)) rsel = RSEL_CONTROL;
      else if (paddr == ADDR_W'(OFS_STATUS))  rsel = RSEL_STATUS;
   end

   assign wr_control = access_wr && (rsel == RSEL_CONTROL);
   assign wr_status  = access_wr && (rsel == RSEL_STATUS);
endmodule

// File: rtl/csr_control_bank.sv
module csr_control_bank #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned MODE_LSB = 1,
   parameter int unsigned MODE_W   = 3,
   parameter int unsigned THR_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic              en_q,
   output logic [MODE_W-1:0] mode_q,
   output logic [THR_W-1:0]  thr_q
);
   localparam int unsigned THR_LSB  = DATA_W - THR_W;
   localparam int unsigned MODE_MSB = MODE_LSB + MODE_W - 1;

   if (MODE_LSB == 0 || MODE_MSB >= THR_LSB) begin : g_bad_layout
      $error("csr_control_bank: mode field overlaps enable or threshold");
   end

   logic unused_wbits;
   if (THR_LSB > MODE_MSB + 1) begin : g_gap
      assign unused_wbits = ^wdata[THR_LSB-1:MODE_MSB+1];
   end else begin : g_nogap
      assign unused_wbits = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= '0;
         thr_q  <= '0;
      end else if (wr_en) begin
         en_q   <= wdata[0];
         mode_q <= wdata[MODE_MSB:MODE_LSB];
         thr_q  <= wdata[DATA_W-1:THR_LSB];
      end
   end

   assert_mode_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mode_q == $past(wdata[MODE_MSB:MODE_LSB])));
   assert_thr_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (thr_q == $past(wdata[DATA_W-1:THR_LSB])));
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({en_q, mode_q, thr_q}));
endmodule

// File: rtl/csr_done_flag.sv
module csr_done_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_wr,
   input  logic sw_clr_bit,
   input  logic en,
   output logic done_q,
   output logic irq
);
   logic clr_req;
   assign clr_req = sw_wr && sw_clr_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       done_q <= 1'b0;
      else if (hw_set)  done_q <= 1'b1;
      else if (clr_req) done_q <= 1'b0;
   end

   assign irq = done_q && en;

   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> done_q);
   assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && sw_clr_bit && !hw_set) |=> !done_q);
   assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_set && !(sw_wr && sw_clr_bit)) |=> $stable(done_q));
endmodule

// File: rtl/apb_csr_block.sv
module apb_csr_block
   import apb_csr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned MODE_W    = 3,
   parameter int unsigned THR_W     = 16,
   parameter logic [7:0]  REV_MAJOR = 8'h01,
   parameter logic [7:0]  REV_MINOR = 8'h02,
   parameter logic [15:0] CAP_MASK  = 16'h0003
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic              core_busy,
   input  logic              core_done_set,
   output logic              ctl_en,
   output logic [MODE_W-1:0] ctl_mode,
   output logic [THR_W-1:0]  ctl_thresh,
   output logic              irq
);
   localparam int unsigned MODE_LSB = 1;
   localparam int unsigned THR_LSB  = DATA_W - THR_W;
   localparam int unsigned GAP_W    = THR_LSB - MODE_LSB - MODE_W;

   if (DATA_W != 32) begin : g_bad_width
      $error("apb_csr_block: identification layout needs DATA_W == 32");
   end

   logic  wr_control, wr_status, done_q;
   rsel_e rsel;
   logic [DATA_W-1:0] ident_word, control_word, status_word, rdata;

   csr_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
      .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
      .wr_control(wr_control), .wr_status(wr_status), .rsel(rsel));

   csr_control_bank #(.DATA_W(DATA_W), .MODE_LSB(MODE_LSB), .MODE_W(MODE_W),
                      .THR_W(THR_W)) u_control (
      .clk(pclk), .rst_n(presetn), .wr_en(wr_control), .wdata(pwdata),
      .en_q(ctl_en), .mode_q(ctl_mode), .thr_q(ctl_thresh));

   csr_done_flag u_done (
      .clk(pclk), .rst_n(presetn), .hw_set(core_done_set),
      .sw_wr(wr_status), .sw_clr_bit(pwdata[1]), .en(ctl_en),
      .done_q(done_q), .irq(irq));

   assign ident_word   = {REV_MAJOR, REV_MINOR, CAP_MASK};
   assign control_word = {ctl_thresh, {GAP_W{1'b0}}, ctl_mode, ctl_en};
   assign status_word  = {{(DATA_W-2){1'b0}}, done_q, core_busy};

   always_comb begin
      unique case (rsel)
         RSEL_IDENT:   rdata = ident_word;
         RSEL_CONTROL: rdata = control_word;
         RSEL_STATUS:  rdata = status_word;
         default:      rdata = '0;
      endcase
   end

   assign prdata  = (psel && !pwrite) ? rdata : '0;
   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   assert_ident_major_R1: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && penable && pready && !pwrite && paddr == ADDR_W'(OFS_IDENT))
      |-> (prdata[31:24] == REV_MAJOR));
   assert_busy_view_R5: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !pwrite && paddr == ADDR_W'(OFS_STATUS)) |-> (prdata[0] == core_busy));
   assert_irq_gate_R8: assert property (@(posedge pclk) disable iff (!presetn)
      irq |-> ctl_en);
   assert_unmapped_zero_R9: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !pwrite && rsel == RSEL_NONE) |-> (prdata == '0));
endmodule

// File: tb/apb_csr_block_bench.sv
module apb_csr_block_bench;
   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic        core_busy = 1'b0, core_done_set = 1'b0;
   logic        ctl_en, irq;
   logic [2:0]  ctl_mode;
   logic [15:0] ctl_thresh;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 pclk = ~pclk;

   apb_csr_block u_apb_csr_block (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .core_busy(core_busy),
      .core_done_set(core_done_set), .ctl_en(ctl_en), .ctl_mode(ctl_mode),
      .ctl_thresh(ctl_thresh), .irq(irq));

   typedef struct packed {
      logic        is_wr;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'h00, 32'h0102_0003, 8'd1},   // R1 identification word
      '{1'b0, 8'h04, 32'h0000_0000, 8'd2},   // R2 control reset
      '{1'b0, 8'h08, 32'h0000_0000, 8'd2},   // R2 status reset
      '{1'b1, 8'h04, 32'hABCD_FFFF, 8'd3},   // R3 full write
      '{1'b0, 8'h04, 32'hABCD_000F, 8'd3},   // R3 reserved bits read zero
      '{1'b1, 8'h04, 32'h0000_0038, 8'd3},   // R3 ones at [5:3]
      '{1'b0, 8'h04, 32'h0000_0008, 8'd3},   // R3 only bit 3 captured
      '{1'b1, 8'h04, 32'h0000_000A, 8'd3},   // R3 mode 5, en 0
      '{1'b0, 8'h04, 32'h0000_000A, 8'd3},
      '{1'b1, 8'h00, 32'hFFFF_FFFF, 8'd10},  // R10 write to identification
      '{1'b0, 8'h00, 32'h0102_0003, 8'd10},
      '{1'b1, 8'h0C, 32'h1234_5678, 8'd9},   // R9 unmapped write
      '{1'b0, 8'h0C, 32'h0000_0000, 8'd9},
      '{1'b0, 8'h04, 32'h0000_000A, 8'd9},   // R9 control untouched
      '{1'b1, 8'h08, 32'hFFFF_FFFF, 8'd5},   // R5 write status, busy low
      '{1'b0, 8'h08, 32'h0000_0000, 8'd5}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic apb_write(input logic [7:0] a, input logic [31:0] d, input bit with_set);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
      @(negedge pclk);
      penable = 1'b1;
      if (with_set) core_done_set = 1'b1;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0; core_done_set = 1'b0;
   endtask

   task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
      @(negedge pclk);
      penable = 1'b1;
      #1 d = prdata;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic pulse_done;
      @(negedge pclk);
      core_done_set = 1'b1;
      @(negedge pclk);
      core_done_set = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge pclk);
      presetn = 1'b1;
      @(negedge pclk);
      check(ctl_en == 0 && ctl_mode == 0 && ctl_thresh == 0 && irq == 0, "R2 outputs",
            {12'h0, ctl_thresh, ctl_mode, ctl_en}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_wr) apb_write(VECS[i].addr, VECS[i].data, 1'b0);
         else begin
            apb_read(VECS[i].addr, rd);
            check(rd == VECS[i].data, $sformatf("R%0d vector %0d", VECS[i].req, i),
                  rd, VECS[i].data);
         end
      end

      // R3 control outputs after mode 5 write
      check(ctl_mode == 3'd5 && ctl_en == 1'b0 && ctl_thresh == 16'h0, "R3 ctl outputs",
            {12'h0, ctl_thresh, ctl_mode, ctl_en}, 32'h0000_000A);

      // R4 setup phase only: no write
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 8'h04; pwdata = 32'hFFFF_FFFF;
      @(negedge pclk);
      psel = 1'b0; pwrite = 1'b0;
      apb_read(8'h04, rd);
      check(rd == 32'h0000_000A, "R4 setup-only", rd, 32'h0000_000A);

      // R9 handshake during an access phase
      @(negedge pclk);
      psel = 1'b1; penable = 1'b1; paddr = 8'h0C;
      #1 check(pready == 1'b1 && pslverr == 1'b0, "R9 pready/pslverr",
               {30'h0, pslverr, pready}, 32'h1);
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;

      // R5 busy follows input, writes ignored
      core_busy = 1'b1;
      apb_write(8'h08, 32'h0000_0000, 1'b0);
      apb_read(8'h08, rd);
      check(rd == 32'h1, "R5 busy high", rd, 32'h1);
      core_busy = 1'b0;

      // R6 set by core
      pulse_done();
      apb_read(8'h08, rd);
      check(rd == 32'h2, "R6 done set", rd, 32'h2);
      check(irq == 1'b0, "R8 irq masked", {31'h0, irq}, 32'h0);

      // R8 enable then irq
      apb_write(8'h04, 32'h0000_0001, 1'b0);
      check(irq == 1'b1, "R8 irq asserted", {31'h0, irq}, 32'h1);

      // R6 write 0 keeps flag
      apb_write(8'h08, 32'h0000_0000, 1'b0);
      apb_read(8'h08, rd);
      check(rd == 32'h2, "R6 write zero keeps", rd, 32'h2);

      // R6 write 1 clears
      apb_write(8'h08, 32'h0000_0002, 1'b0);
      apb_read(8'h08, rd);
      check(rd == 32'h0, "R6 write one clears", rd, 32'h0);
      check(irq == 1'b0, "R8 irq after clear", {31'h0, irq}, 32'h0);

      // R7 set and clear on same edge
      pulse_done();
      apb_write(8'h08, 32'h0000_0002, 1'b1);
      apb_read(8'h08, rd);
      check(rd == 32'h2, "R7 set wins", rd, 32'h2);
      check(irq == 1'b1, "R8 irq with set", {31'h0, irq}, 32'h1);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule